// File: doc/BRIEF.md
# Serial Password Gate with Attempt Limiter

This block decides whether a host may open a session. The host sends a 64-bit secret one byte at a time, and the block checks it against one of three stored secrets: read, write or configuration. The block answers each byte with an acknowledge or a refusal. It never shows the verdict straight away. After the last secret byte it stays in a fixed busy period, and during that period every byte is refused. Once the period is over, the only way to learn the verdict is to send the probe byte C0h. The block acknowledges the probe only when the secret matched.

An 8-bit attempt counter is checked against an 8-bit limit that the host supplies. When limiting is on and the counter equals the limit, the session is refused outright. When limiting is on, a wrong secret adds one to the counter, and the counter wraps from 255 to 0. A right secret clears the counter only when the clear option is set. A replace mode lets the host enter a new secret twice after a granted probe. The new secret is stored only when both copies agree. No port ever carries a stored secret.

The states are as follows. IDLE waits for `begin_i`. From IDLE the block moves to ENTRY, or to DENY when the class is reserved or the attempt limit has been reached. ENTRY moves to BUSY on the eighth byte. BUSY moves to VERDICT when the timer runs out. From VERDICT a matching probe leads to OPEN, or to NEW_A in replace mode. NEW_A moves to NEW_B after eight bytes, and NEW_B returns to IDLE after eight more. `abort_i` sends any state back to IDLE.

Top module: `pv_top`

## Requirements
- R1: In ENTRY every byte gets an acknowledge, one cycle after its strobe. Byte k (0 to 7, with the first byte as k=0) is compared with bits [8k+7:8k] of the stored secret for the selected class. The class codes are 0 = read, 1 = write and 2 = configuration.
- R2: At `begin_i`, if `rc_en_i` is 1 and `retry_cnt_o` equals `retry_lim_i`, the block enters DENY. In DENY every byte is refused and the counter does not change until `abort_i`.
- R3: When `rc_en_i` is 1, a mismatching secret adds one to the counter at the eighth byte, with 255 wrapping to 0. When `rc_en_i` is 0, the counter does not change.
- R4: When `rc_en_i` is 1, a matching secret clears the counter if `rc_clr_i` is 1, and otherwise leaves it unchanged.
- R5: For BUSY_CYC cycles after the eighth byte, every byte is refused, the probe code included.
- R6: After the busy period, byte C0h is acknowledged only if the secret matched. Any other byte is refused, and so is C0h after a mismatch.
- R7: After a granted probe in normal mode, `grant_o` is 1 and every byte is acknowledged until `abort_i`.
- R8: In replace mode, a granted probe is followed by two copies of 8 bytes. The first 15 bytes are acknowledged. The 16th byte is acknowledged, with a one-cycle `upd_en_o` one-hot pulse for the class (bit 0 = read, bit 1 = write, bit 2 = configuration), only if both copies are equal. Otherwise it is refused and the stored secret does not change.
- R9: `abort_i` during ENTRY returns the block to IDLE with the counter unchanged.
- R10: After reset the block is in IDLE, `grant_o`, `resp_vld_o` and `upd_en_o` are 0, the counter is 0 and all stored secrets are zero.
- R11: Class code 3 is reserved and always leads to DENY.
- R12: `cnt_wr_i` loads `cnt_wdata_i` into the counter, so a counter above the limit wraps before it reaches the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| begin_i | input | 1 | Start a session (used in IDLE) |
| cls_i | input | 2 | Secret class for the session |
| newpw_i | input | 1 | Replace mode for the session |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Incoming byte |
| abort_i | input | 1 | Stop condition; return to IDLE |
| rc_en_i | input | 1 | Attempt limiting enable |
| rc_clr_i | input | 1 | Clear counter on a correct secret |
| retry_lim_i | input | 8 | Attempt limit |
| cnt_wr_i | input | 1 | Counter load strobe |
| cnt_wdata_i | input | 8 | Counter load value |
| resp_vld_o | output | 1 | A response is present this cycle |
| resp_ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| grant_o | output | 1 | Session open |
| upd_en_o | output | 3 | One-hot secret update pulse |
| retry_cnt_o | output | 8 | Attempt counter |

## Verification
The bench aims at the cases where the verdict could leak. It probes during BUSY, and it probes after a mismatch once the busy period is over. A design that skipped the busy period, or that acknowledged any probe after it, would give an early or false acknowledge. The counter is driven past 255, held with the clear option off, and driven up to the limit. A design that saturated the counter, cleared it regardless of the option, or checked the limit after entry instead of before would show the wrong count or acknowledge bytes in DENY. Replace mode is run with copies that differ only in the last byte, and the old secret is then shown to still open a session. An abort in the middle of entry must leave the count unchanged.

// File: rtl/pv_pkg.sv
package pv_pkg;
    localparam int BYTE_W = 8;
    localparam int NCLS   = 3;
    localparam logic [BYTE_W-1:0] PROBE_CODE = 8'hC0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_BUSY,
        ST_VERDICT,
        ST_OPEN,
        ST_NEW_A,
        ST_NEW_B,
        ST_DENY
    } pv_state_e;

    typedef enum logic [1:0] {
        CLS_READ  = 2'd0,
        CLS_WRITE = 2'd1,
        CLS_CFG   = 2'd2,
        CLS_RSVD  = 2'd3
    } pv_cls_e;
endpackage

// File: rtl/pv_busy.sv
module pv_busy #(
    parameter int CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= CW'(CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pv_retry.sv
module pv_retry #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    input  logic             ok_i,
    input  logic             en_i,
    input  logic             clr_on_ok_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (step_i && en_i) begin
            if (!ok_i)
                cnt_q <= cnt_q + 1'b1;
            else if (clr_on_ok_i)
                cnt_q <= '0;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pv_pwstore.sv
module pv_pwstore #(
    parameter int PW_W  = 64,
    parameter int IDX_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 sel_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  logic [pv_pkg::BYTE_W-1:0]  byte_i,
    input  logic [pv_pkg::NCLS-1:0]    wr_en_i,
    input  logic [PW_W-1:0]            wr_val_i,
    output logic                       eq_o
);
    localparam int OFF_W = IDX_W + 3;
    logic [OFF_W-1:0] off;
    logic [pv_pkg::NCLS-1:0] hit;

    assign off = {idx_i, 3'b000};

    for (genvar k = 0; k < pv_pkg::NCLS; k++) begin : g_slot
        logic [PW_W-1:0] pw_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pw_q <= '0;
            else if (wr_en_i[k])
                pw_q <= wr_val_i;
        end
        assign hit[k] = (sel_i == 2'(k)) && (pw_q[off +: pv_pkg::BYTE_W] == byte_i);
    end

    assign eq_o = |hit;
endmodule

// File: rtl/pv_top.sv
module pv_top
    import pv_pkg::*;
#(
    parameter int BUSY_CYC = 500,
    parameter int PW_BYTES = 8,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              begin_i,
    input  logic [1:0]        cls_i,
    input  logic              newpw_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              abort_i,
    input  logic              rc_en_i,
    input  logic              rc_clr_i,
    input  logic [CNT_W-1:0]  retry_lim_i,
    input  logic              cnt_wr_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    output logic              resp_vld_o,
    output logic              resp_ack_o,
    output logic              grant_o,
    output logic [2:0]        upd_en_o,
    output logic [CNT_W-1:0]  retry_cnt_o
);
    localparam int PW_W  = PW_BYTES * BYTE_W;
    localparam int IDX_W = $clog2(PW_BYTES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PW_BYTES - 1);

    pv_state_e          state_q, state_n;
    logic [IDX_W-1:0]   idx_q, idx_n;
    logic               match_q, match_n;
    logic               diff_q, diff_n;
    logic               newpw_q, newpw_n;
    logic [1:0]         cls_q, cls_n;
    logic [PW_W-1:0]    cand_q, cand_n;
    logic [IDX_W+2:0]   off;

    logic               rsp_vld_n, rsp_ack_n;
    logic [NCLS-1:0]    upd_n;
    logic               step, busy_load, busy, byte_eq;

    assign off = {idx_q, 3'b000};

    pv_pwstore #(.PW_W(PW_W), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (cls_q),
        .idx_i    (idx_q),
        .byte_i   (byte_i),
        .wr_en_i  (upd_n),
        .wr_val_i (cand_q),
        .eq_o     (byte_eq)
    );

    pv_retry #(.CNT_W(CNT_W)) u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cnt_wr_i),
        .load_val_i  (cnt_wdata_i),
        .step_i      (step),
        .ok_i        (match_n),
        .en_i        (rc_en_i),
        .clr_on_ok_i (rc_clr_i),
        .cnt_o       (retry_cnt_o)
    );

    pv_busy #(.CYC(BUSY_CYC)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (busy_load),
        .busy_o (busy)
    );

    always_comb begin
        state_n   = state_q;
        idx_n     = idx_q;
        match_n   = match_q;
        diff_n    = diff_q;
        newpw_n   = newpw_q;
        cls_n     = cls_q;
        cand_n    = cand_q;
        rsp_vld_n = 1'b0;
        rsp_ack_n = 1'b0;
        upd_n     = '0;
        step      = 1'b0;
        busy_load = 1'b0;

        if (abort_i) begin
            state_n = ST_IDLE;
        end else begin
            if (state_q != ST_IDLE)
                rsp_vld_n = byte_vld_i;
            unique case (state_q)
                ST_IDLE: begin
                    if (begin_i) begin
                        cls_n   = cls_i;
                        newpw_n = newpw_i;
                        idx_n   = '0;
                        match_n = 1'b1;
                        if (cls_i == CLS_RSVD || (rc_en_i && retry_cnt_o == retry_lim_i))
                            state_n = ST_DENY;
                        else
                            state_n = ST_ENTRY;
                    end
                end
                ST_ENTRY: begin
                    if (byte_vld_i) begin
                        rsp_ack_n = 1'b1;
                        match_n   = match_q & byte_eq;
                        if (idx_q == LAST) begin
                            step      = 1'b1;
                            busy_load = 1'b1;
                            state_n   = ST_BUSY;
                        end else begin
                            idx_n = idx_q + 1'b1;
                        end
                    end
                end
                ST_BUSY: begin
                    if (!busy)
                        state_n = ST_VERDICT;
                end
                ST_VERDICT: begin
                    if (byte_vld_i && byte_i == PROBE_CODE && match_q) begin
                        rsp_ack_n = 1'b1;
                        idx_n     = '0;
                        diff_n    = 1'b0;
                        state_n   = newpw_q ? ST_NEW_A : ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    rsp_ack_n = byte_vld_i;
                end
                ST_NEW_A: begin
                    if (byte_vld_i) begin
                        rsp_ack_n            = 1'b1;
                        cand_n[off +: BYTE_W] = byte_i;
                        idx_n                = idx_q + 1'b1;
                        if (idx_q == LAST)
                            state_n = ST_NEW_B;
                    end
                end
                ST_NEW_B: begin
                    if (byte_vld_i) begin
                        diff_n = diff_q | (byte_i != cand_q[off +: BYTE_W]);
                        idx_n  = idx_q + 1'b1;
                        if (idx_q == LAST) begin
                            rsp_ack_n = !diff_n;
                            if (!diff_n)
                                upd_n[cls_q] = 1'b1;
                            state_n = ST_IDLE;
                        end else begin
                            rsp_ack_n = 1'b1;
                        end
                    end
                end
                ST_DENY: begin
                    rsp_ack_n = 1'b0;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            match_q <= 1'b0;
            diff_q  <= 1'b0;
            newpw_q <= 1'b0;
            cls_q   <= 2'd0;
            cand_q  <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            match_q <= match_n;
            diff_q  <= diff_n;
            newpw_q <= newpw_n;
            cls_q   <= cls_n;
            cand_q  <= cand_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_vld_o <= 1'b0;
            resp_ack_o <= 1'b0;
            grant_o    <= 1'b0;
            upd_en_o   <= '0;
        end else begin
            resp_vld_o <= rsp_vld_n;
            resp_ack_o <= rsp_ack_n;
            grant_o    <= (state_n == ST_OPEN);
            upd_en_o   <= upd_n;
        end
    end
endmodule

// File: rtl/pv_chk.sv
module pv_chk
    import pv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pv_state_e        state,
    input  logic             match,
    input  logic             begin_i,
    input  logic             byte_vld_i,
    input  logic             abort_i,
    input  logic             rc_en_i,
    input  logic [CNT_W-1:0] retry_lim_i,
    input  logic             cnt_wr_i,
    input  logic             resp_vld_o,
    input  logic             resp_ack_o,
    input  logic [2:0]       upd_en_o,
    input  logic [CNT_W-1:0] retry_cnt_o
);
    // R1: every byte in an active state gets a response
    a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !abort_i && state != ST_IDLE) |=> resp_vld_o);

    // R2: limit reached at start leads to refusal
    a_r2_refuse_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && begin_i && !abort_i && rc_en_i && retry_cnt_o == retry_lim_i)
        |=> state == ST_DENY);

    a_r2_deny_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DENY && byte_vld_i) |=> !resp_ack_o);

    // R3/R4: counter only moves by +1 (wrapping) or to zero unless loaded
    a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr_i) && retry_cnt_o != $past(retry_cnt_o))
        |-> (retry_cnt_o == $past(retry_cnt_o) + 1'b1 || retry_cnt_o == '0));

    // R5: no acknowledge while the busy timer runs
    a_r5_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && byte_vld_i) |=> !resp_ack_o);

    // R6: a mismatched secret is never acknowledged at the probe
    a_r6_probe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VERDICT && byte_vld_i && !match) |=> !resp_ack_o);

    // R8: update enables are one-hot at most
    a_r8_upd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_en_o));

    // R9: abort always returns to idle
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> state == ST_IDLE);
endmodule

bind pv_top pv_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .match       (match_q),
    .begin_i     (begin_i),
    .byte_vld_i  (byte_vld_i),
    .abort_i     (abort_i),
    .rc_en_i     (rc_en_i),
    .retry_lim_i (retry_lim_i),
    .cnt_wr_i    (cnt_wr_i),
    .resp_vld_o  (resp_vld_o),
    .resp_ack_o  (resp_ack_o),
    .upd_en_o    (upd_en_o),
    .retry_cnt_o (retry_cnt_o)
);

// File: tb/sim_pv_top.sv
`timescale 1ns/1ps
module sim_pv_top;
    localparam int BUSY = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic begin_i = 1'b0, newpw_i = 1'b0, byte_vld_i = 1'b0, abort_i = 1'b0;
    logic [1:0] cls_i = 2'd0;
    logic [7:0] byte_i = 8'd0;
    logic rc_en_i = 1'b0, rc_clr_i = 1'b0, cnt_wr_i = 1'b0;
    logic [7:0] retry_lim_i = 8'd0, cnt_wdata_i = 8'd0;
    logic resp_vld_o, resp_ack_o, grant_o;
    logic [2:0] upd_en_o;
    logic [7:0] retry_cnt_o;

    always #10 clk = ~clk;

    pv_top #(.BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .begin_i(begin_i), .cls_i(cls_i), .newpw_i(newpw_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .abort_i(abort_i), .rc_en_i(rc_en_i),
        .rc_clr_i(rc_clr_i), .retry_lim_i(retry_lim_i), .cnt_wr_i(cnt_wr_i),
        .cnt_wdata_i(cnt_wdata_i), .resp_vld_o(resp_vld_o), .resp_ack_o(resp_ack_o),
        .grant_o(grant_o), .upd_en_o(upd_en_o), .retry_cnt_o(retry_cnt_o)
    );

    int checks = 0;
    int errors = 0;
    logic [63:0] m_pw [4];
    int m_cnt = 0;
    bit mon_en = 1'b0;
    logic [2:0] last_upd;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference: counter compared on every clock
    always @(negedge clk) begin
        cyc++;
        if (mon_en) chk(retry_cnt_o == 8'(m_cnt), "R3 counter vs model", retry_cnt_o, m_cnt);
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input logic [7:0] b, input bit exp_ack, input int cnt_after, input string tag);
        byte_i = b; byte_vld_i = 1'b1;
        @(posedge clk);
        m_cnt = cnt_after;
        @(negedge clk);
        byte_vld_i = 1'b0;
        last_upd = upd_en_o;
        chk(resp_vld_o == 1'b1, tag, resp_vld_o, 1);
        chk(resp_ack_o == exp_ack, tag, resp_ack_o, exp_ack);
    endtask

    task automatic start(input logic [1:0] c, input bit np);
        cls_i = c; newpw_i = np; begin_i = 1'b1;
        @(negedge clk);
        begin_i = 1'b0;
    endtask

    task automatic stop_bus();
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(grant_o == 1'b0, "R9 grant after abort", grant_o, 0);
    endtask

    task automatic load_cnt(input logic [7:0] v);
        cnt_wdata_i = v; cnt_wr_i = 1'b1;
        @(posedge clk);
        m_cnt = v;
        @(negedge clk);
        cnt_wr_i = 1'b0;
    endtask

    // full attempt; returns after probe (session left open/new-entry if granted)
    task automatic attempt(input logic [1:0] c, input logic [63:0] pw, input bit en,
                           input bit clr, input logic [7:0] lim, input bit np, output bit granted);
        bit refused, match;
        int nc;
        rc_en_i = en; rc_clr_i = clr; retry_lim_i = lim;
        refused = (c == 2'd3) || (en && m_cnt == int'(lim));
        match = !refused && (pw == m_pw[c]);
        nc = m_cnt;
        if (!refused && en) nc = match ? (clr ? 0 : m_cnt) : ((m_cnt + 1) % 256);
        start(c, np);
        for (int i = 0; i < 8; i++)
            send(pw[8*i +: 8], !refused, (i == 7) ? nc : m_cnt,
                 refused ? "R2 R11 refused byte" : "R1 entry byte ack");
        granted = 1'b0;
        if (refused) return;
        send(8'hC0, 1'b0, m_cnt, "R5 probe during busy");
        repeat (BUSY + 2) @(negedge clk);
        if (match && !np) send(8'h55, 1'b0, m_cnt, "R6 non-probe byte");
        send(8'hC0, match, m_cnt, "R6 probe verdict");
        granted = match;
        chk(grant_o == (match && !np), "R7 grant level", grant_o, match && !np);
    endtask

    localparam logic [63:0] NEWW = 64'h0123_4567_89AB_CDEF;

    initial begin
        bit g;
        for (int k = 0; k < 4; k++) m_pw[k] = '0;
        repeat (3) @(negedge clk);
        chk(resp_vld_o == 0 && grant_o == 0 && upd_en_o == 0 && retry_cnt_o == 0,
            "R10 reset outputs", {resp_vld_o, grant_o, upd_en_o, retry_cnt_o}, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);

        // correct zero read secret, data phase
        attempt(2'd0, 64'h0, 1'b1, 1'b1, 8'd3, 1'b0, g);
        send(8'h3C, 1'b1, m_cnt, "R7 open data ack");
        stop_bus();

        // replace write secret
        attempt(2'd1, 64'h0, 1'b1, 1'b1, 8'd3, 1'b1, g);
        for (int i = 0; i < 8; i++) send(NEWW[8*i +: 8], 1'b1, m_cnt, "R8 first copy");
        for (int i = 0; i < 8; i++) send(NEWW[8*i +: 8], 1'b1, m_cnt, "R8 second copy");
        chk(last_upd == 3'b010, "R8 update pulse", last_upd, 3'b010);
        m_pw[1] = NEWW;
        @(negedge clk);
        chk(upd_en_o == 3'b000, "R8 pulse one cycle", upd_en_o, 0);

        // replace read secret, copies differ in last byte
        attempt(2'd0, 64'h0, 1'b1, 1'b1, 8'd3, 1'b1, g);
        for (int i = 0; i < 8; i++) send(NEWW[8*i +: 8], 1'b1, m_cnt, "R8 first copy b");
        for (int i = 0; i < 7; i++) send(NEWW[8*i +: 8], 1'b1, m_cnt, "R8 second copy b");
        send(8'h00, 1'b0, m_cnt, "R8 mismatch nack");
        chk(last_upd == 3'b000, "R8 no update", last_upd, 0);

        // old zero write secret now wrong
        attempt(2'd1, 64'h0, 1'b1, 1'b1, 8'd3, 1'b0, g);
        stop_bus();
        attempt(2'd1, 64'h0, 1'b1, 1'b1, 8'd3, 1'b0, g);
        stop_bus();
        // correct, no clear: stays 2
        attempt(2'd1, NEWW, 1'b1, 1'b0, 8'd3, 1'b0, g);
        stop_bus();
        chk(retry_cnt_o == 8'd2, "R4 kept without clear", retry_cnt_o, 2);
        attempt(2'd1, 64'h0, 1'b1, 1'b1, 8'd3, 1'b0, g);
        stop_bus();
        // limit reached
        attempt(2'd0, 64'h0, 1'b1, 1'b1, 8'd3, 1'b0, g);
        chk(g == 1'b0, "R2 limit refused", g, 0);
        stop_bus();
        // raise limit, correct with clear
        attempt(2'd1, NEWW, 1'b1, 1'b1, 8'd10, 1'b0, g);
        stop_bus();
        chk(retry_cnt_o == 8'd0, "R4 cleared", retry_cnt_o, 0);
        // disabled: wrong does not count
        attempt(2'd1, 64'h1, 1'b0, 1'b1, 8'd0, 1'b0, g);
        stop_bus();
        chk(retry_cnt_o == 8'd0, "R3 disabled no count", retry_cnt_o, 0);

        // abort mid entry
        rc_en_i = 1'b1; retry_lim_i = 8'd10;
        start(2'd1, 1'b0);
        for (int i = 0; i < 4; i++) send(8'hEE, 1'b1, m_cnt, "R9 partial entry");
        stop_bus();
        chk(retry_cnt_o == 8'd0, "R9 count unchanged", retry_cnt_o, 0);

        // wrap from 255 and start above limit
        load_cnt(8'd255);
        attempt(2'd2, 64'h5, 1'b1, 1'b1, 8'd10, 1'b0, g);
        stop_bus();
        chk(retry_cnt_o == 8'd0, "R3 wrap to zero", retry_cnt_o, 0);
        load_cnt(8'd200);
        attempt(2'd2, 64'h0, 1'b1, 1'b1, 8'd10, 1'b0, g);
        chk(g == 1'b1, "R12 above limit accepted", g, 1);
        stop_bus();

        // reserved class
        attempt(2'd3, 64'h0, 1'b0, 1'b0, 8'd10, 1'b0, g);
        stop_bus();
        // read secret unchanged after failed replace
        attempt(2'd0, 64'h0, 1'b0, 1'b0, 8'd10, 1'b0, g);
        chk(g == 1'b1, "R8 old read secret kept", g, 1);
        stop_bus();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule